// File: doc/BRIEF.md
# Receive Descriptor Ring Manager

This block tracks the hardware side of a circular ring of receive descriptors kept in host memory. Software programs the ring base address, the ring length in bytes, a control word and the tail index. The block holds the head index, which only hardware moves. It presents the address of the descriptor that the next incoming frame should use. After each frame has been written back, the head moves on by one slot.

The frame side works like a valid/ready pair. `desc_valid` is the ready half: it is high when the ring is enabled, has a nonzero size and has at least one free slot. `frame_done` is the valid half, a one-cycle pulse. A pulse seen while `desc_valid` is high is accepted and moves the head. A pulse seen while the ring is enabled but `desc_valid` is low is refused: the frame is dropped and an overrun pulse is raised. A pulse seen while the ring is disabled is ignored. There is no stall: the upstream side must sample `desc_valid` before it completes a frame.

The block also raises a low-descriptor pulse when the number of free slots falls to a fraction of the ring that software selects. Both event pulses go to the interrupt logic.

Top module: `rx_ring_mgr`

## Requirements
- R1: A synchronous active-low reset clears the base, length, control, head and tail registers to zero. While in reset and right after it, `desc_valid`, `evt_overrun` and `evt_low_desc` are 0 and `desc_addr` is 0.
- R2: Register writes select a register with `reg_sel`: 0 is the base address, 1 is the length in bytes, 2 is the tail index and 3 is control. The slot count is the length divided by 16 (bits [IDX_W+3:4]), and the head wraps from count-1 back to 0.
- R3: `desc_addr` equals the base address plus 16 times the head index. It follows the head combinationally.
- R4: `desc_valid` is 1 exactly when control bit 1 (enable) is set, the slot count is nonzero and the head differs from the tail.
- R5: A `frame_done` pulse sampled while `desc_valid` is 1 advances the head by one slot at that clock edge.
- R6: A `frame_done` pulse sampled while the ring is enabled and `desc_valid` is 0 leaves the head unchanged. `evt_overrun` is then 1 for exactly the following cycle.
- R7: While the enable bit is 0, `frame_done` changes neither the head nor `desc_addr`, and it raises no event.
- R8: A tail write with a value at or above the slot count stores 0. Only bits [IDX_W-1:0] of the write data are used.
- R9: Control bits [9:8] set the low threshold T: 0 gives count/2, 1 gives count/4, 2 gives count/8, and 3 turns the event off. The free count is (tail - head) mod count. `evt_low_desc` is 1 for one cycle after an edge that takes the free count from above T to T or below, while the ring is enabled.
- R10: A tail write and a head advance at the same edge both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low global reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 base, 1 length, 2 tail, 3 control) |
| reg_wdata | input | 32 | Register write data |
| frame_done | input | 1 | Pulse: a received frame has been written back |
| desc_valid | output | 1 | A descriptor is available for the next frame |
| desc_addr | output | ADDR_W | Host address of the descriptor at the head |
| evt_overrun | output | 1 | Pulse: a frame was refused because the ring was full |
| evt_low_desc | output | 1 | Pulse: free slots fell to the low threshold |

## Verification
The main stepping is driven through an eight-slot ring. A long run of accepted frames shows that the head wraps from slot 7 back to slot 0. A mid-run tail write that itself wraps shows that the free count is taken modulo the ring size. Driving frames until the head reaches the tail separates a correct refusal, where the head holds and an overrun pulse follows, from a head that runs past the tail. A frame landing in the same cycle as a tail write shows that neither update is lost. Each threshold code is then tried on a transition that only that code would flag, so that a swapped or ignored select field is caught.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_LEN  = 2'd1,
    SEL_TAIL = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  localparam int CTRL_EN_BIT  = 1;
  localparam int CTRL_THR_LSB = 8;
  localparam int SLOT_SHIFT   = 4;

  typedef enum logic [1:0] {
    THR_HALF    = 2'd0,
    THR_QUARTER = 2'd1,
    THR_EIGHTH  = 2'd2,
    THR_OFF     = 2'd3
  } thr_sel_e;
endpackage

// File: rtl/rx_ring_regs.sv
module rx_ring_regs
  import rx_ring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [31:0]       wr_data,
  output logic [ADDR_W-1:0] base_q,
  output logic [IDX_W-1:0]  slot_cnt,
  output logic              ring_en,
  output logic [1:0]        thr_sel,
  output logic [IDX_W-1:0]  tail_q,
  output logic [IDX_W-1:0]  tail_nxt
);
  localparam int LEN_MSB = IDX_W + SLOT_SHIFT - 1;

  logic             wr_base, wr_len, wr_tail, wr_ctrl;
  logic [IDX_W-1:0] tail_req;

  assign wr_base = wr_en && (wr_sel == SEL_BASE);
  assign wr_len  = wr_en && (wr_sel == SEL_LEN);
  assign wr_tail = wr_en && (wr_sel == SEL_TAIL);
  assign wr_ctrl = wr_en && (wr_sel == SEL_CTRL);

  assign tail_req = wr_data[IDX_W-1:0];

  always_comb begin
    tail_nxt = tail_q;
    if (wr_tail) begin
      if (tail_req >= slot_cnt) tail_nxt = '0;
      else                      tail_nxt = tail_req;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      slot_cnt <= '0;
      ring_en  <= 1'b0;
      thr_sel  <= 2'd0;
      tail_q   <= '0;
    end else begin
      if (wr_base) base_q   <= wr_data[ADDR_W-1:0];
      if (wr_len)  slot_cnt <= wr_data[LEN_MSB:SLOT_SHIFT];
      if (wr_ctrl) begin
        ring_en <= wr_data[CTRL_EN_BIT];
        thr_sel <= wr_data[CTRL_THR_LSB+1:CTRL_THR_LSB];
      end
      tail_q <= tail_nxt;
    end
  end

  // R8: a stored tail is always inside the ring, or zero
  assert_tail_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tail |=> (tail_q < slot_cnt) || (tail_q == '0));
endmodule

// File: rtl/rx_ring_head.sv
module rx_ring_head #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ring_en,
  input  logic [IDX_W-1:0]  slot_cnt,
  input  logic [IDX_W-1:0]  tail_q,
  input  logic [ADDR_W-1:0] base_q,
  input  logic              frame_done,
  output logic [IDX_W-1:0]  head_q,
  output logic [IDX_W-1:0]  head_nxt,
  output logic              avail,
  output logic [ADDR_W-1:0] desc_addr,
  output logic              ovr_evt
);
  localparam int SLOT_SHIFT = rx_ring_pkg::SLOT_SHIFT;

  logic             accept;
  logic             refuse;
  logic [IDX_W-1:0] head_inc;

  assign avail    = ring_en && (slot_cnt != '0) && (head_q != tail_q);
  assign accept   = frame_done && avail;
  assign refuse   = frame_done && ring_en && !avail;
  assign head_inc = head_q + 1'b1;

  always_comb begin
    head_nxt = head_q;
    if (accept) begin
      if (head_inc >= slot_cnt) head_nxt = '0;
      else                      head_nxt = head_inc;
    end
  end

  assign desc_addr = base_q + (ADDR_W'(head_q) << SLOT_SHIFT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      ovr_evt <= 1'b0;
    end else begin
      head_q  <= head_nxt;
      ovr_evt <= refuse;
    end
  end

  // R5: an accepted frame moves the head
  assert_head_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && avail && slot_cnt > 1) |=> (head_q != $past(head_q)));

  // R6: a refused frame holds the head and pulses overrun
  assert_drop_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && ring_en && !avail) |=> (ovr_evt && head_q == $past(head_q)));

  // R7: a disabled ring never moves and never reports
  assert_idle_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ring_en |=> (head_q == $past(head_q)) && !ovr_evt);
endmodule

// File: rtl/rx_ring_thresh.sv
module rx_ring_thresh
  import rx_ring_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ring_en,
  input  logic [1:0]       thr_sel,
  input  logic [IDX_W-1:0] slot_cnt,
  input  logic [IDX_W-1:0] head_q,
  input  logic [IDX_W-1:0] head_nxt,
  input  logic [IDX_W-1:0] tail_q,
  input  logic [IDX_W-1:0] tail_nxt,
  output logic             low_evt
);
  localparam int CW = IDX_W + 1;

  function automatic logic [CW-1:0] free_slots(input logic [IDX_W-1:0] h,
                                               input logic [IDX_W-1:0] t,
                                               input logic [IDX_W-1:0] n);
    if (t >= h) free_slots = CW'(t) - CW'(h);
    else        free_slots = CW'(t) + CW'(n) - CW'(h);
  endfunction

  logic [CW-1:0] free_cur, free_new, limit;
  logic          thr_on;

  assign free_cur = free_slots(head_q, tail_q, slot_cnt);
  assign free_new = free_slots(head_nxt, tail_nxt, slot_cnt);

  always_comb begin
    thr_on = 1'b1;
    limit  = '0;
    case (thr_sel)
      THR_HALF:    limit = CW'(slot_cnt >> 1);
      THR_QUARTER: limit = CW'(slot_cnt >> 2);
      THR_EIGHTH:  limit = CW'(slot_cnt >> 3);
      default:     thr_on = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) low_evt <= 1'b0;
    else        low_evt <= ring_en && thr_on && (free_cur > limit) && (free_new <= limit);
  end

  // R9: the low pulse only follows an enabled ring with the event switched on
  assert_low_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    low_evt |-> $past(ring_en) && ($past(thr_sel) != THR_OFF));
endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  input  logic              frame_done,
  output logic              desc_valid,
  output logic [ADDR_W-1:0] desc_addr,
  output logic              evt_overrun,
  output logic              evt_low_desc
);
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  slot_cnt, tail_q, tail_nxt, head_q, head_nxt;
  logic              ring_en;
  logic [1:0]        thr_sel;

  rx_ring_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_sel(reg_sel), .wr_data(reg_wdata),
    .base_q(base_q), .slot_cnt(slot_cnt), .ring_en(ring_en), .thr_sel(thr_sel),
    .tail_q(tail_q), .tail_nxt(tail_nxt)
  );

  rx_ring_head #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_head (
    .clk(clk), .rst_n(rst_n), .ring_en(ring_en), .slot_cnt(slot_cnt), .tail_q(tail_q),
    .base_q(base_q), .frame_done(frame_done), .head_q(head_q), .head_nxt(head_nxt),
    .avail(desc_valid), .desc_addr(desc_addr), .ovr_evt(evt_overrun)
  );

  rx_ring_thresh #(.IDX_W(IDX_W)) u_thr (
    .clk(clk), .rst_n(rst_n), .ring_en(ring_en), .thr_sel(thr_sel), .slot_cnt(slot_cnt),
    .head_q(head_q), .head_nxt(head_nxt), .tail_q(tail_q), .tail_nxt(tail_nxt),
    .low_evt(evt_low_desc)
  );

  // R4: a descriptor is never offered while the ring is off
  assert_valid_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ring_en) |-> !desc_valid);
endmodule

// File: tb/rx_ring_mgr_test.sv
module rx_ring_mgr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic        frame_done = 1'b0;
  logic        desc_valid;
  logic [31:0] desc_addr;
  logic        evt_overrun, evt_low_desc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_ring_mgr uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .frame_done(frame_done), .desc_valid(desc_valid), .desc_addr(desc_addr),
    .evt_overrun(evt_overrun), .evt_low_desc(evt_low_desc)
  );

  // entry: {op[1:0], tail[15:0], valid, overrun, low, addr[31:0]}
  // op 0 idle, 1 frame, 2 tail write, 3 frame plus tail write
  localparam int NV = 16;
  localparam logic [52:0] VEC [NV] = '{
    {2'd1, 16'd0, 1'b1, 1'b0, 1'b0, 32'h1010},
    {2'd1, 16'd0, 1'b1, 1'b0, 1'b0, 32'h1020},
    {2'd1, 16'd0, 1'b1, 1'b0, 1'b1, 32'h1030},
    {2'd1, 16'd0, 1'b1, 1'b0, 1'b0, 32'h1040},
    {2'd0, 16'd0, 1'b1, 1'b0, 1'b0, 32'h1040},
    {2'd2, 16'd1, 1'b1, 1'b0, 1'b0, 32'h1040},
    {2'd1, 16'd0, 1'b1, 1'b0, 1'b1, 32'h1050},
    {2'd1, 16'd0, 1'b1, 1'b0, 1'b0, 32'h1060},
    {2'd1, 16'd0, 1'b1, 1'b0, 1'b0, 32'h1070},
    {2'd1, 16'd0, 1'b1, 1'b0, 1'b0, 32'h1000},
    {2'd1, 16'd0, 1'b0, 1'b0, 1'b0, 32'h1010},
    {2'd1, 16'd0, 1'b0, 1'b1, 1'b0, 32'h1010},
    {2'd0, 16'd0, 1'b0, 1'b0, 1'b0, 32'h1010},
    {2'd2, 16'd3, 1'b1, 1'b0, 1'b0, 32'h1010},
    {2'd3, 16'd6, 1'b1, 1'b0, 1'b0, 32'h1020},
    {2'd1, 16'd0, 1'b1, 1'b0, 1'b0, 32'h1030}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic v, input logic [31:0] a,
                         input logic o, input logic l);
    chk(req, "desc_valid", 32'(desc_valid), 32'(v));
    chk(req, "desc_addr", desc_addr, a);
    chk(req, "evt_overrun", 32'(evt_overrun), 32'(o));
    chk(req, "evt_low_desc", 32'(evt_low_desc), 32'(l));
  endtask

  task automatic step(input logic fr, input logic wr, input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    frame_done = fr; reg_we = wr; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    frame_done = 1'b0; reg_we = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    step(1'b0, 1'b1, sel, d);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_out("R1", 1'b0, 32'h0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_out("R1", 1'b0, 32'h0, 1'b0, 1'b0);

    // R2 R3 ring setup: 8 slots at 0x1000, half threshold
    wr(2'd0, 32'h1000);
    wr(2'd1, 32'h80);
    wr(2'd3, 32'h002);
    wr(2'd2, 32'd7);
    chk_out("R3", 1'b1, 32'h1000, 1'b0, 1'b0);

    // R2 R5 R6 R9 R10 table walk
    for (int i = 0; i < NV; i++) begin
      logic [52:0] e;
      e = VEC[i];
      step(e[52] || (e[51] && e[52]) ? e[51] : e[51] & 1'b0 | (e[52:51] == 2'd1 || e[52:51] == 2'd3),
           e[52], 2'd2, 32'(e[50:35]));
      chk_out($sformatf("R5/R10 vec%0d", i), e[34], e[31:0], e[33], e[32]);
    end

    // R7 disabled ring ignores frames (head 3, tail 6)
    wr(2'd3, 32'h000);
    chk_out("R7", 1'b0, 32'h1030, 1'b0, 1'b0);
    step(1'b1, 1'b0, 2'd0, 32'h0);
    chk_out("R7", 1'b0, 32'h1030, 1'b0, 1'b0);
    wr(2'd3, 32'h002);
    chk_out("R7", 1'b1, 32'h1030, 1'b0, 1'b0);

    // R8 tail at the slot count is stored as zero
    do_reset();
    wr(2'd1, 32'h80);
    wr(2'd3, 32'h002);
    wr(2'd2, 32'd8);
    chk_out("R8", 1'b0, 32'h0, 1'b0, 1'b0);
    wr(2'd2, 32'd2);
    chk_out("R8", 1'b1, 32'h0, 1'b0, 1'b0);

    // R9 quarter then eighth threshold
    do_reset();
    wr(2'd1, 32'h80);
    wr(2'd3, 32'h102);
    wr(2'd2, 32'd3);
    step(1'b1, 1'b0, 2'd0, 32'h0);
    chk_out("R9 quarter", 1'b1, 32'h10, 1'b0, 1'b1);
    wr(2'd3, 32'h202);
    step(1'b1, 1'b0, 2'd0, 32'h0);
    chk_out("R9 eighth", 1'b1, 32'h20, 1'b0, 1'b1);

    // R9 threshold off
    do_reset();
    wr(2'd1, 32'h80);
    wr(2'd3, 32'h302);
    wr(2'd2, 32'd2);
    step(1'b1, 1'b0, 2'd0, 32'h0);
    chk_out("R9 off", 1'b1, 32'h10, 1'b0, 1'b0);

    // R4 zero-size ring offers nothing; refused frame reports overrun (R6)
    do_reset();
    wr(2'd3, 32'h002);
    wr(2'd2, 32'd3);
    chk_out("R4", 1'b0, 32'h0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 2'd0, 32'h0);
    chk_out("R6", 1'b0, 32'h0, 1'b1, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule